// File: doc/BRIEF.md
# PLL Divider Parameter Solver

This block takes a requested output clock period and works out the settings for a frequency synthesizer: a two-bit post-divider code, the post-divide factor that code selects, and an eight-bit feedback divider. It receives the reference-clock period, the reference divider and the target period together as one request. From these it forms a scaled ratio `q = (ref_period * ref_div * 4) / tgt_period` by integer division. It checks that `q` is usable, picks the post-divider by comparing `q` against power-of-two thresholds, and derives the feedback divider as `q * factor / 8`.

The request side is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` drops while a solve is running, so a request offered during that time waits or is simply withdrawn. The result side has no back-pressure. `res_valid` pulses for one cycle, and the result outputs then hold their values until the next result. The quotient comes from an internal restoring shift-subtract divider that produces one bit per cycle.

Top module: `pll_div_solver`

## Requirements
- R1: After reset `req_ready` is 1, and `res_valid`, `res_err`, `post_code`, `post_real` and `fb_div` are all 0.
- R2: The ratio is q = floor(ref_period * ref_div * 4 / tgt_period), computed at the full operand widths without overflow.
- R3: If q < 128 or q > 2040, the result has `res_err` = 1 and `post_code`, `post_real` and `fb_div` are all 0.
- R4: For 128 <= q <= 2040, `post_code` is the number of true conditions among q < 1024, q < 512 and q < 256, so it is 0 to 3.
- R5: `post_real` is the post-divide factor for the code: codes 0, 1, 2 and 3 give 1, 2, 4 and 8.
- R6: For an in-range q, `fb_div` = floor(q * post_real / 8), and it always lies between 128 and 255.
- R7: A target period of 0 is never divided by. It yields an error result, marked as R3 describes, on the accepting edge itself.
- R8: `req_ready` is low from the accepting edge until the edge that raises `res_valid`. Requests offered while it is low are not taken and do not alter the result in flight.
- R9: `res_valid` is a one-cycle pulse. For a nonzero target it rises on the clock edge DW+1 cycles after the accepting edge.
- R10: The result outputs change only on an edge that raises `res_valid`, and otherwise keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Solver idle and able to take a request |
| ref_period | input | PER_W | Reference clock period |
| ref_div | input | RDIV_W | Reference divider |
| tgt_period | input | PER_W | Requested output clock period |
| res_valid | output | 1 | One-cycle result strobe |
| res_err | output | 1 | Ratio out of range or target period zero |
| post_code | output | 2 | Post-divider code |
| post_real | output | 4 | Post-divide factor selected by the code |
| fb_div | output | 8 | Feedback divider |

## Verification
The bench builds the block with its defaults: PER_W = 16, RDIV_W = 8 and DW = 32. The numerator therefore reaches 26 bits, so an all-ones reference period and divider can be driven to check that the ratio is computed without overflow. With DW = 32 each nonzero solve takes a fixed 33 edges, and the bench measures that delay directly. The operand ranges are wide enough to place q exactly on each side of every threshold, including 127/128, 255/256, 511/512, 1023/1024 and 2040/2041. They also reach a truncating division and a request offered while busy.

// File: rtl/pll_solver_pkg.sv
package pll_solver_pkg;

  typedef enum logic [0:0] {
    SOLVE_IDLE = 1'b0,
    SOLVE_BUSY = 1'b1
  } solve_state_t;

  // Post-divide factor per code; code 4 is the odd divide-by-three tap.
  function automatic logic [3:0] post_div_value(input logic [2:0] code);
    case (code)
      3'd0:    post_div_value = 4'd1;
      3'd1:    post_div_value = 4'd2;
      3'd2:    post_div_value = 4'd4;
      3'd3:    post_div_value = 4'd8;
      3'd4:    post_div_value = 4'd3;
      default: post_div_value = 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/serial_divider.sv
module serial_divider #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] quotient,
  output logic          busy,
  output logic          done
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(DW);

  logic [DW-1:0] rem_q, quo_q, dsr_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [DW:0]   shifted;
  logic [DW+1:0] diff;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo_q[DW-1]};
    diff    = {1'b0, shifted} - {2'b00, dsr_q};
    fits    = ~diff[DW+1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start && cnt_q == '0) begin
      rem_q  <= '0;
      quo_q  <= dividend;
      dsr_q  <= divisor;
      cnt_q  <= CNT_LOAD;
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q  <= fits ? DW'(diff) : DW'(shifted);
      quo_q  <= {quo_q[DW-2:0], fits};
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign quotient = quo_q;
  assign busy     = (cnt_q != '0);
  assign done     = done_q;

  // R9: completion strobe lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: completion only after the bit count has run out
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8: a start while busy does not reload the divisor
  a_r8_divisor_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dsr_q));

endmodule

// File: rtl/pll_post_select.sv
module pll_post_select #(
  parameter int QW       = 32,
  parameter int LOW_LIM  = 128,
  parameter int HIGH_LIM = 2040,
  parameter int TOP_THR  = 1024,
  parameter int NUM_THR  = 3,
  parameter int FB_W     = 8
) (
  input  logic [QW-1:0]   q,
  output logic            out_of_range,
  output logic [1:0]      code,
  output logic [3:0]      real_div,
  output logic [FB_W-1:0] fb
);
  import pll_solver_pkg::*;

  localparam int QL  = $clog2(HIGH_LIM + 1);
  localparam int PRW = QL + 4;

  logic [NUM_THR-1:0] below;
  logic [PRW-1:0]     prod;

  for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
    assign below[i] = (q < QW'(TOP_THR >> i));
  end

  always_comb begin
    out_of_range = (q < QW'(LOW_LIM)) || (q > QW'(HIGH_LIM));
    code         = 2'($countones(below));
    real_div     = post_div_value({1'b0, code});
    prod         = PRW'(q[QL-1:0]) * PRW'(real_div);
    fb           = FB_W'(prod >> 3);
  end

endmodule

// File: rtl/pll_div_solver.sv
module pll_div_solver #(
  parameter int PER_W  = 16,
  parameter int RDIV_W = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PER_W-1:0]  ref_period,
  input  logic [RDIV_W-1:0] ref_div,
  input  logic [PER_W-1:0]  tgt_period,
  output logic              res_valid,
  output logic              res_err,
  output logic [1:0]        post_code,
  output logic [3:0]        post_real,
  output logic [7:0]        fb_div
);
  import pll_solver_pkg::*;

  localparam int NUM_W = PER_W + RDIV_W + 2;

  solve_state_t  st_q;
  logic [NUM_W-1:0] num_w;
  logic          accept, tgt_zero, div_start;
  logic [DW-1:0] q_w;
  logic          div_busy, div_done;
  logic          sel_err;
  logic [1:0]    sel_code;
  logic [3:0]    sel_real;
  logic [7:0]    sel_fb;

  assign num_w     = (NUM_W'(ref_period) * NUM_W'(ref_div)) << 2;
  assign req_ready = (st_q == SOLVE_IDLE);
  assign accept    = req_valid && req_ready;
  assign tgt_zero  = (tgt_period == '0);
  assign div_start = accept && !tgt_zero;

  serial_divider #(.DW(DW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (DW'(num_w)),
    .divisor  (DW'(tgt_period)),
    .quotient (q_w),
    .busy     (div_busy),
    .done     (div_done)
  );

  pll_post_select #(.QW(DW), .FB_W(8)) u_sel (
    .q            (q_w),
    .out_of_range (sel_err),
    .code         (sel_code),
    .real_div     (sel_real),
    .fb           (sel_fb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= SOLVE_IDLE;
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      post_code <= '0;
      post_real <= '0;
      fb_div    <= '0;
    end else begin
      res_valid <= 1'b0;
      case (st_q)
        SOLVE_IDLE: begin
          if (accept && tgt_zero) begin
            res_valid <= 1'b1;
            res_err   <= 1'b1;
            post_code <= '0;
            post_real <= '0;
            fb_div    <= '0;
          end else if (accept) begin
            st_q <= SOLVE_BUSY;
          end
        end
        SOLVE_BUSY: begin
          if (div_done) begin
            st_q      <= SOLVE_IDLE;
            res_valid <= 1'b1;
            res_err   <= sel_err;
            post_code <= sel_err ? 2'd0 : sel_code;
            post_real <= sel_err ? 4'd0 : sel_real;
            fb_div    <= sel_err ? 8'd0 : sel_fb;
          end
        end
        default: st_q <= SOLVE_IDLE;
      endcase
    end
  end

  // R6: a good result has a feedback divider in 128..255
  a_r6_fb_band: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err) |-> fb_div[7]);
  // R3: an error result carries no divider values
  a_r3_err_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (fb_div == 8'd0 && post_code == 2'd0 && post_real == 4'd0));
  // R5: factor is the power of two named by the code
  a_r5_real_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err) |-> (post_real == (4'd1 << post_code)));
  // R8: no new request is taken while the divider runs
  a_r8_not_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> !req_ready);
  // R9: result strobe is a single cycle
  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R10: outputs hold between results
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(fb_div) && $stable(post_code) && $stable(post_real) && $stable(res_err)));

endmodule

// File: tb/pll_div_solver_bench.sv
`timescale 1ns/1ps
module pll_div_solver_bench;
  localparam int PER_W  = 16;
  localparam int RDIV_W = 8;
  localparam int DW     = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [PER_W-1:0]  ref_period = '0;
  logic [RDIV_W-1:0] ref_div = '0;
  logic [PER_W-1:0]  tgt_period = '0;
  logic res_valid, res_err;
  logic [1:0] post_code;
  logic [3:0] post_real;
  logic [7:0] fb_div;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pll_div_solver #(.PER_W(PER_W), .RDIV_W(RDIV_W), .DW(DW)) u_pll_div_solver (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .ref_period(ref_period), .ref_div(ref_div), .tgt_period(tgt_period),
    .res_valid(res_valid), .res_err(res_err), .post_code(post_code),
    .post_real(post_real), .fb_div(fb_div)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Independent model of the solve.
  task automatic model(input longint rp, input longint rd, input longint tp,
                       output bit e, output int c, output int r, output int f);
    longint q;
    e = 0; c = 0; r = 0; f = 0;
    if (tp == 0) begin e = 1; return; end
    q = (rp * rd * 4) / tp;
    if (q < 128 || q > 2040) begin e = 1; return; end
    c = (q < 1024) + (q < 512) + (q < 256);
    r = 1 << c;
    f = int'((q * r) / 8);
  endtask

  task automatic offer(input int rp, input int rd, input int tp);
    @(negedge clk);
    ref_period = PER_W'(rp);
    ref_div    = RDIV_W'(rd);
    tgt_period = PER_W'(tp);
    req_valid  = 1'b1;
    chk("R8 ready when idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_result(output int k);
    k = 1;
    while (!res_valid && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_vec(input string tag, input int rp, input int rd, input int tp);
    bit e; int c, r, f, k;
    model(rp, rd, tp, e, c, r, f);
    offer(rp, rd, tp);
    wait_result(k);
    chk({"R9 latency ", tag}, k, (tp == 0) ? 1 : DW + 2);
    chk({"R3 err ", tag}, res_err, e);
    chk({"R4 code ", tag}, post_code, c);
    chk({"R5 factor ", tag}, post_real, r);
    chk({"R6 fb ", tag}, fb_div, f);
    @(negedge clk);
    chk({"R9 pulse ", tag}, res_valid, 0);
  endtask

  task automatic test_reset();
    chk("R1 ready", req_ready, 1);
    chk("R1 valid", res_valid, 0);
    chk("R1 err", res_err, 0);
    chk("R1 code", post_code, 0);
    chk("R1 factor", post_real, 0);
    chk("R1 fb", fb_div, 0);
  endtask

  task automatic test_busy_ignored();
    bit e; int c, r, f, k, extra;
    model(1000, 3, 7, e, c, r, f);
    offer(1000, 3, 7);
    @(negedge clk);
    ref_period = 16'd32; ref_div = 8'd1; tgt_period = 16'd1; req_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8 not ready while busy", req_ready, 0);
    end
    req_valid = 1'b0;
    wait_result(k);
    chk("R8 result from first request fb", fb_div, f);
    chk("R8 result from first request code", post_code, c);
    extra = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (res_valid) extra++;
    end
    chk("R8 ignored request gives no result", extra, 0);
    chk("R10 fb held", fb_div, f);
    chk("R10 code held", post_code, c);
    chk("R10 factor held", post_real, r);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_vec("R2 plain q1600", 1000, 2, 5);
    run_vec("R2 truncating q1714", 1000, 3, 7);
    run_vec("q1024", 256, 1, 1);
    run_vec("q1023", 1023, 1, 4);
    run_vec("q512", 128, 1, 1);
    run_vec("q511", 511, 1, 4);
    run_vec("q256", 64, 1, 1);
    run_vec("q255", 255, 1, 4);
    run_vec("q128 low edge", 32, 1, 1);
    run_vec("q127 below", 127, 1, 4);
    run_vec("q2040 high edge", 510, 1, 1);
    run_vec("q2041 above", 2041, 1, 4);
    run_vec("R2 wide operands", 65535, 255, 65535);
    run_vec("R2 wide overflow", 65535, 255, 1);
    run_vec("R7 zero target", 500, 4, 0);
    test_busy_ignored();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule